// File: doc/BRIEF.md
# Multi-Lane Frame Corner-Turn Buffer

This block sits between stages of a parallel FFT datapath that moves several complex samples per clock. Each frame of `FRAME` samples arrives as `FRAME/LANES` beats of `LANES` samples, and the block hands the frame on in the other of two lane orderings. In the continuous ordering, beat k carries frame indices k*LANES up to k*LANES+LANES-1, lane by lane. In the strided ordering, beat k carries indices k, k+S, k+2S and so on, where the stride S is `FRAME/LANES`. The `mode` input selects the direction, and every output beat carries the frame index of each of its lanes.

Storage is two frame halves used in ping-pong fashion, so one frame can be written while the one before it is read out. Each half is spread across `LANES` single-port-write memory banks. A sample with index i = q*S + s (q below `LANES`, s below S) lives in bank (q+s) mod `LANES` at row s. With this skew, the lanes of one beat always land in distinct banks, in either ordering. The writer moves through the states WR_OPEN (the next beat starts a frame and samples `mode`), WR_FILL (inside a frame) and WR_BLOCKED (the half to be written next still holds an unread frame). WR_OPEN goes to WR_FILL when the first beat is accepted. WR_FILL goes back to WR_OPEN after the last beat if the other half is free, and to WR_BLOCKED if it is not. WR_BLOCKED returns to WR_OPEN once the reader frees that half. The reader has two states. RD_IDLE waits for a full half and moves to RD_DRAIN. RD_DRAIN emits beats and returns to RD_IDLE after the last beat of a frame unless the next half is already full.

`LANES` is 2, 4, 8 or 16, and `FRAME` is a power of two no smaller than `LANES*LANES`.

Top module: `lane_reorder`

## Requirements
- R1: While `rst` is high, `in_ready` and (from the first edge on) `out_valid` are low. Reset discards any frames held or partly written, so nothing is emitted after reset until a new complete frame has been written.
- R2: With `mode`=0 on a frame's first beat, the input is continuous (input beat k lane j holds index k*LANES+j) and the output is strided (output beat k lane j holds index k+j*S).
- R3: With `mode`=1 on a frame's first beat, the input is strided (beat k lane j holds index k+j*S) and the output is continuous (beat k lane j holds index k*LANES+j).
- R4: Lane j of `out_idx` occupies bits [j*IW +: IW], where IW = log2(`FRAME`), and holds the frame index of the sample on lane j of `out_re`/`out_im`. Those lanes occupy bits [j*DW +: DW] and carry the values written for that index, unchanged.
- R5: `mode` is sampled only on the first beat of a frame and is ignored on the rest of that frame. Consecutive frames may use different modes.
- R6: With `out_ready` held high, frames written back to back are accepted at one beat per cycle without `in_ready` falling, across mode changes. With `out_ready` low, two whole frames are accepted, after which `in_ready` stays low.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_re`, `out_im` and `out_idx` hold their values.
- R8: A block in mode 0 feeding a block in mode 1 returns every frame in its original continuous order with its original data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 1 | Ordering for the frame starting on this beat: 0 continuous-to-strided, 1 strided-to-continuous |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Input beat accepted on this edge when in_valid is high |
| in_re | input | LANES*DW | Real parts, lane j at [j*DW +: DW] |
| in_im | input | LANES*DW | Imaginary parts, lane j at [j*DW +: DW] |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Downstream takes the output beat |
| out_re | output | LANES*DW | Real parts, lane j at [j*DW +: DW] |
| out_im | output | LANES*DW | Imaginary parts, lane j at [j*DW +: DW] |
| out_idx | output | LANES*log2(FRAME) | Frame index of each lane |

## Verification
The bench uses a small configuration (four lanes, 32-sample frames) and checks every lane of every output beat against indices and data computed from the requirements. Runs cover both directions, frames that switch mode, and `mode` toggling inside a frame. A design that latched `mode` late would scramble the second half of such frames. A design with a wrong bank skew would return another lane's data even though `out_idx` looked right. The ping-pong boundary is probed by stalling the output until both halves fill, then releasing it. An off-by-one in the full flags would either lose a frame or accept a third one. The bench also resets the block with one frame stored and another half-written, and a design that kept stale full flags would emit a phantom frame. A mode-0 block chained into a mode-1 block must restore the original order, which exposes any asymmetry between the two address maps.

// File: rtl/lane_reorder_pkg.sv
package lane_reorder_pkg;

    typedef enum logic [1:0] {
        WR_OPEN    = 2'd0,
        WR_FILL    = 2'd1,
        WR_BLOCKED = 2'd2
    } wr_state_e;

    typedef enum logic {
        RD_IDLE  = 1'b0,
        RD_DRAIN = 1'b1
    } rd_state_e;

    typedef enum logic {
        ORDER_C2S = 1'b0,
        ORDER_S2C = 1'b1
    } order_e;

endpackage

// File: rtl/lane_reorder_map.sv
// Per-lane address generation: frame index, bank and row of every lane in a beat.
module lane_reorder_map #(
    parameter int  LANES = 4,
    parameter int  FRAME = 32,
    localparam int LOGP  = $clog2(LANES),
    localparam int LOGM  = $clog2(FRAME / LANES),
    localparam int IW    = $clog2(FRAME)
) (
    input  logic [LOGM-1:0]       beat,
    input  logic                  cont_side,
    output logic [LANES*LOGP-1:0] bank_sel,
    output logic [LANES*LOGM-1:0] row_addr,
    output logic [LANES*IW-1:0]   lane_idx
);

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        localparam logic [LOGP-1:0] LJ = LOGP'(j);
        logic [IW-1:0] flat;

        // continuous side: index = beat*LANES + j ; strided side: index = j*S + beat
        assign flat = cont_side ? {beat, LJ} : {LJ, beat};

        // index = q*S + s -> row s, bank (q + s) mod LANES
        assign row_addr[j*LOGM +: LOGM] = flat[LOGM-1:0];
        assign bank_sel[j*LOGP +: LOGP] = flat[IW-1:LOGM] + flat[LOGP-1:0];
        assign lane_idx[j*IW +: IW]     = flat;
    end

endmodule

// File: rtl/lane_reorder_bank.sv
// One storage bank: both frame halves, one write port, asynchronous read.
module lane_reorder_bank #(
    parameter int AW = 4,
    parameter int W  = 32
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] mem [2**AW];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/lane_reorder_ctrl.sv
// Ping-pong sequencing: writer and reader state machines plus per-half full flags.
module lane_reorder_ctrl
    import lane_reorder_pkg::*;
#(
    parameter int  BEATS = 8,
    localparam int BW    = $clog2(BEATS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic          mode_in,
    input  logic          out_free,
    output logic          in_ready,
    output logic          wr_en,
    output logic          wr_half,
    output logic [BW-1:0] wr_beat,
    output order_e        wr_order,
    output logic          rd_en,
    output logic          rd_half,
    output logic [BW-1:0] rd_beat,
    output order_e        rd_order,
    output logic [1:0]    full
);

    wr_state_e     wr_state_q, wr_state_d;
    rd_state_e     rd_state_q, rd_state_d;
    logic          wr_half_q, wr_half_d, rd_half_q, rd_half_d;
    logic [BW-1:0] wr_beat_q, wr_beat_d, rd_beat_q, rd_beat_d;
    logic [1:0]    full_q, full_d;
    logic [1:0]    half_order_q;
    order_e        order_hold_q;
    logic          wr_open_c, rd_go_c, wr_last, rd_last;

    // state register process
    always_ff @(posedge clk) begin
        if (rst) begin
            wr_state_q   <= WR_OPEN;
            rd_state_q   <= RD_IDLE;
            wr_half_q    <= 1'b0;
            rd_half_q    <= 1'b0;
            wr_beat_q    <= '0;
            rd_beat_q    <= '0;
            full_q       <= 2'b00;
            half_order_q <= 2'b00;
            order_hold_q <= ORDER_C2S;
        end else begin
            wr_state_q <= wr_state_d;
            rd_state_q <= rd_state_d;
            wr_half_q  <= wr_half_d;
            rd_half_q  <= rd_half_d;
            wr_beat_q  <= wr_beat_d;
            rd_beat_q  <= rd_beat_d;
            full_q     <= full_d;
            if (wr_en && (wr_state_q == WR_OPEN)) begin
                half_order_q[wr_half_q] <= wr_order;
                order_hold_q            <= wr_order;
            end
        end
    end

    // output and next-state process
    always_comb begin
        wr_open_c = 1'b0;
        wr_order  = order_hold_q;
        unique case (wr_state_q)
            WR_OPEN: begin
                wr_open_c = 1'b1;
                wr_order  = order_e'(mode_in);
            end
            WR_FILL:    wr_open_c = 1'b1;
            WR_BLOCKED: wr_open_c = 1'b0;
            default:    wr_open_c = 1'b0;
        endcase

        unique case (rd_state_q)
            RD_IDLE:  rd_go_c = 1'b0;
            RD_DRAIN: rd_go_c = 1'b1;
            default:  rd_go_c = 1'b0;
        endcase

        in_ready = wr_open_c && !rst;
        wr_en    = in_ready && in_valid;
        rd_en    = rd_go_c && out_free && !rst;
        wr_last  = wr_en && (wr_beat_q == BW'(BEATS - 1));
        rd_last  = rd_en && (rd_beat_q == BW'(BEATS - 1));

        full_d = full_q;
        if (wr_last) full_d[wr_half_q] = 1'b1;
        if (rd_last) full_d[rd_half_q] = 1'b0;

        wr_half_d = wr_half_q ^ wr_last;
        wr_beat_d = wr_beat_q + BW'(wr_en);
        rd_half_d = rd_half_q ^ rd_last;
        rd_beat_d = rd_beat_q + BW'(rd_en);

        if (full_d[wr_half_d])      wr_state_d = WR_BLOCKED;
        else if (wr_beat_d == '0)   wr_state_d = WR_OPEN;
        else                        wr_state_d = WR_FILL;

        rd_state_d = full_d[rd_half_d] ? RD_DRAIN : RD_IDLE;
    end

    assign wr_half  = wr_half_q;
    assign wr_beat  = wr_beat_q;
    assign rd_half  = rd_half_q;
    assign rd_beat  = rd_beat_q;
    assign rd_order = order_e'(half_order_q[rd_half_q]);
    assign full     = full_q;

endmodule

// File: rtl/lane_reorder.sv
// Multi-lane corner-turn buffer between continuous and strided lane orderings.
module lane_reorder
    import lane_reorder_pkg::*;
#(
    parameter int  LANES = 4,
    parameter int  FRAME = 32,
    parameter int  DW    = 16,
    localparam int LOGP  = $clog2(LANES),
    localparam int BEATS = FRAME / LANES,
    localparam int LOGM  = $clog2(BEATS),
    localparam int IW    = $clog2(FRAME),
    localparam int AW    = LOGM + 1,
    localparam int SW    = 2 * DW
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  mode,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [LANES*DW-1:0]   in_re,
    input  logic [LANES*DW-1:0]   in_im,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [LANES*DW-1:0]   out_re,
    output logic [LANES*DW-1:0]   out_im,
    output logic [LANES*IW-1:0]   out_idx
);

    logic                  wr_en, rd_en, wr_half, rd_half, out_free;
    logic [LOGM-1:0]       wr_beat, rd_beat;
    order_e                wr_order, rd_order;
    logic [1:0]            frame_full;
    logic [LANES*LOGP-1:0] wr_bank_sel, rd_bank_sel;
    logic [LANES*LOGM-1:0] wr_row, rd_row;
    logic [LANES*IW-1:0]   wr_idx, rd_idx;
    logic [SW-1:0]         bank_rd [LANES];
    logic [LANES*DW-1:0]   rd_re, rd_im;
    logic                  out_valid_q;
    logic [LANES*DW-1:0]   out_re_q, out_im_q;
    logic [LANES*IW-1:0]   out_idx_q;

    assign out_free = !out_valid_q || out_ready;

    lane_reorder_ctrl #(.BEATS(BEATS)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .mode_in  (mode),
        .out_free (out_free),
        .in_ready (in_ready),
        .wr_en    (wr_en),
        .wr_half  (wr_half),
        .wr_beat  (wr_beat),
        .wr_order (wr_order),
        .rd_en    (rd_en),
        .rd_half  (rd_half),
        .rd_beat  (rd_beat),
        .rd_order (rd_order),
        .full     (frame_full)
    );

    lane_reorder_map #(.LANES(LANES), .FRAME(FRAME)) u_wr_map (
        .beat      (wr_beat),
        .cont_side (wr_order == ORDER_C2S),
        .bank_sel  (wr_bank_sel),
        .row_addr  (wr_row),
        .lane_idx  (wr_idx)
    );

    lane_reorder_map #(.LANES(LANES), .FRAME(FRAME)) u_rd_map (
        .beat      (rd_beat),
        .cont_side (rd_order == ORDER_S2C),
        .bank_sel  (rd_bank_sel),
        .row_addr  (rd_row),
        .lane_idx  (rd_idx)
    );

    // write crossbar (lane -> bank) and read addressing per bank
    for (genvar b = 0; b < LANES; b++) begin : g_bank
        localparam logic [LOGP-1:0] BID = LOGP'(b);
        logic          we_b;
        logic [AW-1:0] wa_b, ra_b;
        logic [SW-1:0] wd_b;

        always_comb begin
            we_b = 1'b0;
            wa_b = '0;
            ra_b = '0;
            wd_b = '0;
            for (int j = 0; j < LANES; j++) begin
                if (wr_bank_sel[j*LOGP +: LOGP] == BID) begin
                    we_b = wr_en;
                    wa_b = {wr_half, wr_row[j*LOGM +: LOGM]};
                    wd_b = {in_re[j*DW +: DW], in_im[j*DW +: DW]};
                end
                if (rd_bank_sel[j*LOGP +: LOGP] == BID) begin
                    ra_b = {rd_half, rd_row[j*LOGM +: LOGM]};
                end
            end
        end

        lane_reorder_bank #(.AW(AW), .W(SW)) u_bank (
            .clk   (clk),
            .we    (we_b),
            .waddr (wa_b),
            .wdata (wd_b),
            .raddr (ra_b),
            .rdata (bank_rd[b])
        );
    end

    // read crossbar (bank -> lane)
    for (genvar j = 0; j < LANES; j++) begin : g_rd_lane
        assign rd_re[j*DW +: DW] = bank_rd[rd_bank_sel[j*LOGP +: LOGP]][SW-1:DW];
        assign rd_im[j*DW +: DW] = bank_rd[rd_bank_sel[j*LOGP +: LOGP]][DW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)             out_valid_q <= 1'b0;
        else if (rd_en)      out_valid_q <= 1'b1;
        else if (out_ready)  out_valid_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rd_en) begin
            out_re_q  <= rd_re;
            out_im_q  <= rd_im;
            out_idx_q <= rd_idx;
        end
    end

    assign out_valid = out_valid_q;
    assign out_re    = out_re_q;
    assign out_im    = out_im_q;
    assign out_idx   = out_idx_q;

endmodule

// File: rtl/lane_reorder_chk.sv
module lane_reorder_chk #(
    parameter int  LANES = 4,
    parameter int  FRAME = 32,
    parameter int  DW    = 16,
    localparam int LOGP  = $clog2(LANES),
    localparam int BEATS = FRAME / LANES,
    localparam int IW    = $clog2(FRAME)
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  in_ready,
    input logic                  out_valid,
    input logic                  out_ready,
    input logic [LANES*DW-1:0]   out_re,
    input logic [LANES*DW-1:0]   out_im,
    input logic [LANES*IW-1:0]   out_idx,
    input logic [1:0]            full,
    input logic                  wr_en,
    input logic                  rd_en,
    input logic [LANES*LOGP-1:0] wr_bank_sel,
    input logic [LANES*LOGP-1:0] rd_bank_sel,
    input logic [LANES*IW-1:0]   wr_idx
);

    function automatic logic lanes_follow_pattern(input logic [LANES*IW-1:0] v);
        logic [IW-1:0] base, step;
        logic ok;
        base = v[0 +: IW];
        step = v[IW +: IW] - base;
        ok = (step == IW'(1)) || (step == IW'(BEATS));
        for (int j = 0; j < LANES; j++) begin
            if (v[j*IW +: IW] != base + IW'(j) * step) ok = 1'b0;
        end
        return ok;
    endfunction

    logic [LANES-1:0] wr_mask, rd_mask;
    logic             out_idx_ok, wr_idx_ok;

    always_comb begin
        wr_mask = '0;
        rd_mask = '0;
        for (int j = 0; j < LANES; j++) begin
            wr_mask[wr_bank_sel[j*LOGP +: LOGP]] = 1'b1;
            rd_mask[rd_bank_sel[j*LOGP +: LOGP]] = 1'b1;
        end
        out_idx_ok = lanes_follow_pattern(out_idx);
        wr_idx_ok  = lanes_follow_pattern(wr_idx);
    end

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !out_valid);                                         // R1
    AST_WR_BANKS_DISTINCT: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (&wr_mask));                                              // R2
    AST_RD_BANKS_DISTINCT: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> (&rd_mask));                                              // R2
    AST_IN_IDX_PATTERN: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> wr_idx_ok);                                               // R3
    AST_OUT_IDX_PATTERN: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_idx_ok);                                          // R4
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (full == 2'b11) |-> !in_ready);                                     // R6
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_re) && $stable(out_im) && $stable(out_idx))); // R7

endmodule

bind lane_reorder lane_reorder_chk #(.LANES(LANES), .FRAME(FRAME), .DW(DW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_ready    (in_ready),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_re      (out_re),
    .out_im      (out_im),
    .out_idx     (out_idx),
    .full        (frame_full),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .wr_bank_sel (wr_bank_sel),
    .rd_bank_sel (rd_bank_sel),
    .wr_idx      (wr_idx)
);

// File: tb/lane_reorder_bench.sv
`timescale 1ns/1ps
module lane_reorder_bench;

    localparam int P  = 4;
    localparam int N  = 32;
    localparam int DW = 16;
    localparam int M  = N / P;
    localparam int IW = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic              mode = 1'b0, t_valid = 1'b0, h_valid = 1'b0;
    logic [P*DW-1:0]   d_re = '0, d_im = '0;
    logic              t_ready, t_ovalid, t_ordy;
    logic [P*DW-1:0]   t_ore, t_oim;
    logic [P*IW-1:0]   t_oidx;
    logic              h_ready, h_ovalid, c_ready, c_ovalid;
    logic [P*DW-1:0]   h_ore, h_oim, c_ore, c_oim;
    logic [P*IW-1:0]   h_oidx, c_oidx;

    lane_reorder #(.LANES(P), .FRAME(N), .DW(DW)) u_lane_reorder (
        .clk(clk), .rst(rst), .mode(mode), .in_valid(t_valid), .in_ready(t_ready),
        .in_re(d_re), .in_im(d_im), .out_valid(t_ovalid), .out_ready(t_ordy),
        .out_re(t_ore), .out_im(t_oim), .out_idx(t_oidx));

    lane_reorder #(.LANES(P), .FRAME(N), .DW(DW)) u_head (
        .clk(clk), .rst(rst), .mode(mode), .in_valid(h_valid), .in_ready(h_ready),
        .in_re(d_re), .in_im(d_im), .out_valid(h_ovalid), .out_ready(c_ready),
        .out_re(h_ore), .out_im(h_oim), .out_idx(h_oidx));

    lane_reorder #(.LANES(P), .FRAME(N), .DW(DW)) u_tail (
        .clk(clk), .rst(rst), .mode(1'b1), .in_valid(h_ovalid), .in_ready(c_ready),
        .in_re(h_ore), .in_im(h_oim), .out_valid(c_ovalid), .out_ready(1'b1),
        .out_re(c_ore), .out_im(c_oim), .out_idx(c_oidx));

    int n_chk = 0, n_err = 0, stalls = 0;
    int tq_f[64], cq_f[64];
    bit tq_m[64];
    int twp = 0, trp = 0, tbeat = 0, cwp = 0, crp = 0, cbeat = 0, chain_beats = 0;
    bit bp_en = 1'b0, ordy_fix = 1'b1, hold_pend = 1'b0;
    logic [P*DW-1:0] hold_re;
    logic [P*IW-1:0] hold_idx;
    logic [15:0] lfsr = 16'hACE1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // output ready: fixed or pseudo-random backpressure, changed just after the edge
    always @(posedge clk) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        #1 t_ordy = bp_en ? lfsr[0] : ordy_fix;
    end

    // monitors sample at the falling edge
    always @(negedge clk) begin
        if (rst) begin
            hold_pend = 1'b0;
        end else begin
            if (hold_pend) begin
                check(t_ovalid && t_ore == hold_re && t_oidx == hold_idx, "R7 hold",
                      int'(t_oidx[IW-1:0]), int'(hold_idx[IW-1:0]));
            end
            hold_pend = t_ovalid && !t_ordy;
            hold_re   = t_ore;
            hold_idx  = t_oidx;
            if (t_ovalid && t_ordy) begin
                for (int j = 0; j < P; j++) begin
                    int e, f;
                    f = tq_f[trp];
                    e = (tq_m[trp] == 1'b0) ? tbeat + j * M : tbeat * P + j;
                    check(int'(t_oidx[j*IW +: IW]) == e, "R4 lane index", int'(t_oidx[j*IW +: IW]), e);
                    check(int'(t_ore[j*DW +: DW]) == f * 64 + e,
                          tq_m[trp] ? "R3 R5 real" : "R2 R5 real", int'(t_ore[j*DW +: DW]), f * 64 + e);
                    check(int'(t_oim[j*DW +: DW]) == 1000 + f * 64 + e,
                          tq_m[trp] ? "R3 imag" : "R2 imag", int'(t_oim[j*DW +: DW]), 1000 + f * 64 + e);
                end
                tbeat++;
                if (tbeat == M) begin tbeat = 0; trp++; end
            end
            if (c_ovalid) begin
                for (int j = 0; j < P; j++) begin
                    int e;
                    e = cbeat * P + j;
                    check(int'(c_oidx[j*IW +: IW]) == e, "R8 chain index", int'(c_oidx[j*IW +: IW]), e);
                    check(int'(c_ore[j*DW +: DW]) == cq_f[crp] * 64 + e, "R8 chain real",
                          int'(c_ore[j*DW +: DW]), cq_f[crp] * 64 + e);
                end
                chain_beats++;
                cbeat++;
                if (cbeat == M) begin cbeat = 0; crp++; end
            end
        end
    end

    // drives one frame (or its first nbeats beats); mode toggles after the first beat
    task automatic send_frame(input int f, input bit md, input bit to_head, input int nbeats);
        for (int k = 0; k < nbeats; k++) begin
            if (k == 0) begin
                if (to_head) begin cq_f[cwp] = f; cwp++; end
                else begin tq_f[twp] = f; tq_m[twp] = md; twp++; end
            end
            for (int j = 0; j < P; j++) begin
                int idx;
                idx = md ? (k + j * M) : (k * P + j);
                d_re[j*DW +: DW] = 16'(f * 64 + idx);
                d_im[j*DW +: DW] = 16'(1000 + f * 64 + idx);
            end
            mode = (k == 0) ? md : !md;
            if (to_head) h_valid = 1'b1; else t_valid = 1'b1;
            while (!(to_head ? h_ready : t_ready)) begin
                stalls++;
                @(negedge clk);
            end
            @(negedge clk);
        end
        t_valid = 1'b0;
        h_valid = 1'b0;
    endtask

    task automatic wait_drain();
        int n;
        n = 0;
        while ((trp != twp || crp != cwp) && n < 2000) begin
            @(negedge clk);
            n++;
        end
        check(n < 2000, "R6 drain", n, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!t_ready, "R1 ready in reset", int'(t_ready), 0);
        check(!t_ovalid, "R1 valid in reset", int'(t_ovalid), 0);
        rst = 1'b0;
        @(negedge clk);
        check(t_ready, "R1 ready after reset", int'(t_ready), 1);
        check(!t_ovalid, "R1 valid after reset", int'(t_ovalid), 0);

        // R6: back-to-back frames with mode changes, output always ready
        stalls = 0;
        for (int f = 0; f < 4; f++) send_frame(f, f[0], 1'b0, M);
        check(stalls == 0, "R6 full rate", stalls, 0);
        wait_drain();

        // R6: output stalled, two frames absorbed, then input held off
        ordy_fix = 1'b0;
        @(negedge clk);
        stalls = 0;
        send_frame(4, 1'b0, 1'b0, M);
        send_frame(5, 1'b1, 1'b0, M);
        check(stalls == 0, "R6 two frames absorbed", stalls, 0);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(!t_ready, "R6 third frame held off", int'(t_ready), 0);
            check(t_ovalid && t_oidx[IW-1:0] == '0, "R7 first beat held", int'(t_oidx[IW-1:0]), 0);
        end
        ordy_fix = 1'b1;
        send_frame(6, 1'b0, 1'b0, M);
        wait_drain();

        // random backpressure, alternating modes
        bp_en = 1'b1;
        for (int f = 7; f < 13; f++) send_frame(f, f[0], 1'b0, M);
        wait_drain();
        bp_en = 1'b0;

        // R1: reset with one frame stored and one half-written
        ordy_fix = 1'b0;
        @(negedge clk);
        send_frame(13, 1'b1, 1'b0, M);
        send_frame(14, 1'b0, 1'b0, 3);
        rst = 1'b1;
        ordy_fix = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        twp = 0; trp = 0; tbeat = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            check(!t_ovalid, "R1 no stale frame", int'(t_ovalid), 0);
        end
        send_frame(15, 1'b1, 1'b0, M);
        wait_drain();

        // R8: mode-0 block feeding a mode-1 block
        for (int f = 16; f < 19; f++) send_frame(f, 1'b0, 1'b1, M);
        wait_drain();
        check(chain_beats == 3 * M, "R8 chain beat count", chain_beats, 3 * M);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule